// File: doc/BRIEF.md
# 16x Baud Tick Generator

This block turns a reference clock into a one-cycle enable pulse that arrives at sixteen times the serial bit rate. A UART transmitter and receiver advance their oversampling logic on that pulse. The rate is set by a 16-bit divisor, and the pulse rate equals the reference clock frequency divided by the divisor. To get a given bit rate, the divisor is therefore the reference frequency divided by sixteen times the bit rate.

A host sets the divisor through a small write port, one 8-bit half at a time, and can read either half back. Whenever a half is written, the internal down-counter is reloaded at once with the new combined value. The new rate therefore takes effect on that edge. The counter does not first finish a possibly very long count under the old divisor. After reset the pulse output stays quiet until the host has written a nonzero divisor.

Top module: `baud_tick_gen`

## Requirements
- R1: A write with `wr_sel` = 0 stores `wr_data` into bits 7:0 of the divisor, and `wr_sel` = 1 stores it into bits 15:8. The tick period follows the combined 16-bit value {high, low}.
- R2: `rd_data` combinationally shows the low half when `rd_sel` = 0 and the high half when `rd_sel` = 1.
- R3: While reset is held, `tick` is 0 and both halves read back as 0.
- R4: `tick` stays 0 from reset until a write leaves the combined divisor nonzero, including after writes that leave it zero.
- R5: With divisor D > 1 and no writes, `tick` is a one-cycle pulse repeating every D clock cycles.
- R6: With divisor 1, `tick` is high on every cycle.
- R7: A write on clock edge W reloads the counter with the new divisor D. `tick` is 0 in the cycle after edge W, and the first pulse follows edge W + D, even when the write lands mid-count.
- R8: Once armed, a divisor of 0 acts as 65536, giving one pulse every 65536 cycles.
- R9: Between reloads the counter decreases by exactly one per clock cycle.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one divisor half |
| wr_sel | input | 1 | Half select for writes: 0 low, 1 high |
| wr_data | input | 8 | Byte to write |
| rd_sel | input | 1 | Half select for read-back: 0 low, 1 high |
| rd_data | output | 8 | Selected divisor half |
| tick | output | 1 | One-cycle enable at 16x the bit rate |

## Verification
On every cycle the assertions check the following:
- the reload of the counter with the latched value after any write;
- the quiet cycle that follows a write;
- the single-step countdown;
- the one-cycle width of each pulse when D > 1;
- the back-to-back pulses when D = 1;
- that no pulse appears before the generator is armed.

Only the bench scenarios can show the following:
- that pulse spacing matches the divisor across several values, including 65536;
- that a mid-count write moves the next pulse to exactly D cycles after the write;
- that the two halves combine in the right order and read back correctly.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
    parameter int BYTE_W    = 8;
    parameter int NUM_BYTES = 2;
    localparam int DIV_W    = BYTE_W * NUM_BYTES;
    localparam int SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SEL_W-1:0]  sel_t;

    // divisor latch state
    typedef struct packed {
        div_t div;
        logic armed;
    } latch_st_t;

    // down-counter state
    typedef struct packed {
        div_t cnt;
        logic tick;
    } cnt_st_t;
endpackage

// File: rtl/baud_div_regs.sv
`timescale 1ns/1ps
module baud_div_regs
    import baud_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  sel_t  wr_sel,
    input  byte_t wr_data,
    output div_t  div_q,
    output div_t  div_next,
    output logic  armed_q
);
    latch_st_t st_d, st_q;
    logic [NUM_BYTES-1:0] byte_we;

    // one write enable per divisor byte
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_we
        assign byte_we[g] = wr_en && (wr_sel == sel_t'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (byte_we[b]) begin
                st_d.div[b*BYTE_W +: BYTE_W] = wr_data;
            end
        end
        // arm once any write leaves a nonzero divisor
        st_d.armed = st_q.armed | (wr_en && (st_d.div != '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_q    = st_q.div;
    assign div_next = st_d.div;
    assign armed_q  = st_q.armed;
endmodule

// File: rtl/baud_down_counter.sv
`timescale 1ns/1ps
module baud_down_counter
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  div_t load_val,
    input  div_t reload_val,
    input  logic armed,
    output div_t cnt_q,
    output logic tick_q
);
    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // host write: restart immediately with the new divisor
            st_d.cnt  = load_val;
            st_d.tick = 1'b0;
        end else if (st_q.cnt == div_t'(1)) begin
            st_d.cnt  = reload_val;
            st_d.tick = armed;
        end else begin
            // zero wraps to all ones: a zero divisor spans 2**DIV_W cycles
            st_d.cnt  = st_q.cnt - div_t'(1);
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q  = st_q.cnt;
    assign tick_q = st_q.tick;
endmodule

// File: rtl/baud_rd_mux.sv
`timescale 1ns/1ps
module baud_rd_mux
    import baud_pkg::*;
(
    input  div_t  div,
    input  sel_t  rd_sel,
    output byte_t rd_data
);
    byte_t slice [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slice
        assign slice[g] = div[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (rd_sel == sel_t'(b)) begin
                rd_data = slice[b];
            end
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [baud_pkg::SEL_W-1:0]  wr_sel,
    input  logic [baud_pkg::BYTE_W-1:0] wr_data,
    input  logic [baud_pkg::SEL_W-1:0]  rd_sel,
    output logic [baud_pkg::BYTE_W-1:0] rd_data,
    output logic                        tick
);
    import baud_pkg::*;

    div_t div_q;
    div_t div_next;
    div_t cnt_q;
    logic armed_q;

    baud_div_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .div_q    (div_q),
        .div_next (div_next),
        .armed_q  (armed_q)
    );

    baud_down_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_en),
        .load_val   (div_next),
        .reload_val (div_q),
        .armed      (armed_q),
        .cnt_q      (cnt_q),
        .tick_q     (tick)
    );

    baud_rd_mux u_rd (
        .div     (div_q),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
`timescale 1ns/1ps
module baud_tick_gen_chk
    import baud_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tick,
    input div_t div,
    input div_t cnt,
    input logic armed
);
    AST_TICK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> armed); // R4
    AST_RELOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == div)); // R7
    AST_WRITE_HUSH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tick); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt != div_t'(1)) |=> (cnt == $past(cnt) - div_t'(1))); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != div_t'(1)) |=> !tick); // R5
    AST_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div == div_t'(1) && !wr_en) |=> tick); // R6
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .tick  (tick),
    .div   (div_q),
    .cnt   (cnt_q),
    .armed (armed_q)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic       wr_sel;
    logic [7:0] wr_data;
    logic       rd_sel;
    logic [7:0] rd_data;
    logic       tick;

    int unsigned cyc = 0;
    int          checks = 0;
    int          fails = 0;
    longint      q[$];
    bit          running = 0;
    bit          done = 0;
    string       cur_req = "R4";

    logic [15:0] m_div = 16'h0000;
    bit          m_armed = 0;
    longint      nxt = 0;

    always #2.5 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .tick    (tick)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint period();
        return (m_div == 16'h0000) ? 65536 : longint'(m_div);
    endfunction

    // monitor: compares tick against the expected-cycle queue every cycle
    always @(negedge clk) begin
        if (running) begin
            bit exp_t;
            while (q.size() > 0 && q[0] < cyc) void'(q.pop_front());
            exp_t = (q.size() > 0 && q[0] == cyc);
            checks++;
            if (tick !== exp_t) begin
                fails++;
                $display("FAIL %s: tick at cycle %0d actual %b expected %b",
                         cur_req, cyc, tick, exp_t);
            end
            if (exp_t) void'(q.pop_front());
        end
    end

    task automatic chk(string req, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // driver: push expected tick cycles below the limit
    task automatic flush(longint limit);
        if (m_armed) begin
            while (nxt < limit) begin
                q.push_back(nxt);
                nxt += period();
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        flush(longint'(cyc) + 1);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_half(bit sel, logic [7:0] data);
        step();
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        if (sel) m_div[15:8] = data;
        else     m_div[7:0]  = data;
        if (m_div != 16'h0000) m_armed = 1;
        nxt = longint'(cyc) + 1 + period();
        step();
        wr_en = 1'b0;
    endtask

    task automatic readback(bit sel, int exp_v, string req);
        rd_sel = sel;
        #1;
        chk(req, int'(rd_data), exp_v);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
        // R3: quiet and cleared during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3", int'(tick), 0);
            readback(1'b0, 0, "R3");
            readback(1'b1, 0, "R3");
        end
        @(posedge clk); #1;
        rst_n   = 1'b1;
        running = 1;

        // R4: no ticks before a nonzero divisor, even after a zero write
        cur_req = "R4";
        idle(20);
        write_half(1'b1, 8'h00);
        idle(40);

        // R5 / R1: divisor 5 from the low half
        cur_req = "R5";
        write_half(1'b0, 8'd5);
        readback(1'b0, 5, "R2");
        readback(1'b1, 0, "R2");
        idle(60);

        // R6: divisor 1
        cur_req = "R6";
        write_half(1'b0, 8'd1);
        idle(30);

        // R7: long count interrupted mid-way
        cur_req = "R7";
        write_half(1'b0, 8'd200);
        idle(50);
        write_half(1'b0, 8'd7);
        idle(45);

        // R1: high half joins: {1,7} = 263
        cur_req = "R1";
        write_half(1'b1, 8'd1);
        readback(1'b1, 1, "R2");
        readback(1'b0, 7, "R2");
        idle(600);

        // R8: zero divisor after arming spans 65536 cycles
        cur_req = "R8";
        write_half(1'b0, 8'd0);
        write_half(1'b1, 8'd0);
        idle(140000);

        step();
        running = 0;
        chk("R8", q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule